// File: doc/BRIEF.md
# I2C Target with Event-Handshake Clock Stretching

This block is an I2C target (slave) engine. It watches a two-wire open-drain bus, finds START, repeated START and STOP conditions, and decodes the first byte of each transfer. It answers either its own 7-bit address or the broadcast address zero, which only accepts writes. It then shifts data bytes in from the controller, or out to it, most significant bit first. Both bus lines are modelled as drive-low enables. The surrounding system combines them with the line levels it reads back.

The local side talks to the engine through a pending-event flag and a 3-bit event code. After every byte the engine acknowledges, it keeps SCL low and raises the flag. This covers the address byte, each received data byte, and each transmitted byte that the controller ACKs. The stretch has no time limit. It ends only when the local side pulses the clear input. Until then no further bit, START or STOP can appear on the bus. In read mode the transmit byte is taken from the local side at that clear, while SCL is still held low. The engine can therefore take part in a broadcast write that is followed by a repeated START and a read addressed to it alone.

Top module: `i2c_tgt_stretch`

## Requirements
- R1: During and right after reset, `scl_oe`, `sda_oe` and `evt` are 0 and `evt_code` is 0.
- R2: When a START is followed by the byte {own_addr, 0}, the engine pulls SDA low for the ninth clock. It then raises `evt` with code 1. A byte {own_addr, 1} gives code 2.
- R3: When a START is followed by the byte 0x00, the engine acknowledges it and raises code 3. When the byte is any other address, including 0x01, the engine does not acknowledge it, raises no event, and reports no event at the STOP that follows.
- R4: After every acknowledged byte, `scl_oe` stays 1 until `evt_clr` is pulsed, however long that takes. It drops on the clock after the pulse. While it is 1, `evt` is 1 and `evt_code` does not change.
- R5: Every data byte that follows an acknowledged write address is acknowledged. It appears on `rx_byte` with the first bit on the wire as bit 7, and raises code 4.
- R6: In read mode, `tx_byte` is captured at the `evt_clr` pulse and driven MSB first. `sda_oe` changes only while SCL reads low.
- R7: An ACK from the controller after a transmitted byte raises code 5 and stretches again. A NACK raises code 6, releases SDA and does not stretch.
- R8: A STOP or repeated START seen after the engine was addressed raises code 7 without stretching. A broadcast write followed by a repeated START and a read of the own address completes with no STOP in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Level read back from the SCL line |
| sda_i | input | 1 | Level read back from the SDA line |
| scl_oe | output | 1 | 1 pulls SCL low (stretch) |
| sda_oe | output | 1 | 1 pulls SDA low (ACK or a 0 data bit) |
| own_addr | input | 7 | The engine's own 7-bit address |
| tx_byte | input | 8 | Byte to transmit, captured at `evt_clr` in read mode |
| evt_clr | input | 1 | One-cycle pulse that clears `evt` and ends a stretch |
| evt | output | 1 | Pending-event flag |
| evt_code | output | 3 | Code of the latest event (1 to 7) |
| rx_byte | output | 8 | Last data byte received |

## Verification
The hardest case to reach is a stretch that the local side never ends while the controller has already let go of SCL. A controller that waits for SCL to read high would hang on it. The bench's controller model releases SCL with SDA held low and waits thousands of cycles. During that wait the line must stay low. Only then does the bench pulse the clear, so the very next edge pair forms a STOP. The broadcast-then-read case is reached by chaining a general-call write, a repeated START and a read in one transfer. During the read the bench answers one byte with ACK and the next with NACK.

// File: rtl/i2c_tgt_pkg.sv
// Package i2c_tgt_pkg
// Shared sizes, event codes and engine states for the I2C target.
// Assumes 7-bit addressing and 8-bit bytes.
package i2c_tgt_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        EV_NONE    = 3'd0,
        EV_ADDR_WR = 3'd1,
        EV_ADDR_RD = 3'd2,
        EV_GCALL   = 3'd3,
        EV_RX_DATA = 3'd4,
        EV_TX_ACK  = 3'd5,
        EV_TX_NACK = 3'd6,
        EV_BUS_END = 3'd7
    } evt_code_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHIFT_IN,
        ST_ACK_OUT,
        ST_HOLD,
        ST_SHIFT_OUT,
        ST_ACK_IN
    } eng_state_t;
endpackage

// File: rtl/i2c_tgt_sync.sv
// Module i2c_tgt_sync
// Brings SCL and SDA into the clock domain through a STAGES-deep flop chain.
// Derives one-cycle SCL edge pulses and START/STOP detections from it.
// Assumes STAGES >= 2 and an idle-high bus at reset.
module i2c_tgt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic scl_d;
    logic sda_d;
    logic scl_s;

    // Synchroniser chains plus one-cycle-old copies for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_d    <= scl_pipe[STAGES-1];
            sda_d    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s = scl_pipe[STAGES-1];
    assign sda_s = sda_pipe[STAGES-1];

    // Edge and bus-condition decode on the synchronised copies
    always_comb begin
        scl_rise  = !scl_d && scl_s;
        scl_fall  = scl_d && !scl_s;
        start_det = scl_d && scl_s && sda_d && !sda_s;
        stop_det  = scl_d && scl_s && !sda_d && sda_s;
    end
endmodule

// File: rtl/i2c_tgt_match.sv
// Module i2c_tgt_match
// Decodes the first byte of a transfer: own-address hit, broadcast hit, direction.
// The broadcast hit is built only when GC_EN is set, and only for writes.
module i2c_tgt_match #(
    parameter int AW    = 7,
    parameter bit GC_EN = 1'b1
) (
    input  logic [AW:0]   addr_byte,
    input  logic [AW-1:0] own_addr,
    output logic          hit_own,
    output logic          hit_gc,
    output logic          is_read
);
    assign is_read = addr_byte[0];
    assign hit_own = (addr_byte[AW:1] == own_addr);

    generate
        if (GC_EN) begin : g_gc
            assign hit_gc = (addr_byte[AW:1] == '0) && !addr_byte[0];
        end else begin : g_no_gc
            assign hit_gc = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/i2c_tgt_engine.sv
// Module i2c_tgt_engine
// Byte-level target state machine: shifts bits in and out, and drives ACK.
// Stretches SCL after each acknowledged byte until evt_clr is pulsed.
// Assumes the clock is many times faster than SCL.
module i2c_tgt_engine
    import i2c_tgt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              hit_own,
    input  logic              hit_gc,
    input  logic              is_read,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              evt_clr,
    output logic [BYTE_W-1:0] in_byte,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic              evt,
    output logic [2:0]        evt_code,
    output logic [BYTE_W-1:0] rx_byte
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

    eng_state_t        st;
    evt_code_t         code_q;
    logic [BYTE_W-1:0] sh_in;
    logic [BYTE_W-1:0] sh_out;
    logic [CNT_W-1:0]  bit_cnt;
    logic              is_addr;
    logic              rd_mode;
    logic              active;
    logic              ack_rx;
    logic              ev_set;
    evt_code_t         ev_new;

    assign in_byte  = sh_in;
    assign evt_code = code_q;

    // Choose which event, if any, is raised this cycle
    always_comb begin
        ev_set = 1'b0;
        ev_new = EV_NONE;
        if (start_det || stop_det) begin
            ev_set = active;
            ev_new = EV_BUS_END;
        end else begin
            case (st)
                ST_ACK_OUT: begin
                    ev_set = scl_fall;
                    if (!is_addr)     ev_new = EV_RX_DATA;
                    else if (hit_gc)  ev_new = EV_GCALL;
                    else if (is_read) ev_new = EV_ADDR_RD;
                    else              ev_new = EV_ADDR_WR;
                end
                ST_ACK_IN: begin
                    ev_set = scl_fall;
                    ev_new = ack_rx ? EV_TX_ACK : EV_TX_NACK;
                end
                default: ;
            endcase
        end
    end

    // Event flag: a new event wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt    <= 1'b0;
            code_q <= EV_NONE;
        end else if (ev_set) begin
            evt    <= 1'b1;
            code_q <= ev_new;
        end else if (evt_clr) begin
            evt    <= 1'b0;
        end
    end

    // Bus-side state machine: shifting, ACK drive, stretch and release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            sh_in   <= '0;
            sh_out  <= '0;
            bit_cnt <= '0;
            is_addr <= 1'b0;
            rd_mode <= 1'b0;
            active  <= 1'b0;
            ack_rx  <= 1'b0;
            scl_oe  <= 1'b0;
            sda_oe  <= 1'b0;
            rx_byte <= '0;
        end else if (start_det) begin
            st      <= ST_SHIFT_IN;
            is_addr <= 1'b1;
            bit_cnt <= '0;
            sda_oe  <= 1'b0;
            active  <= 1'b0;
        end else if (stop_det) begin
            st      <= ST_IDLE;
            sda_oe  <= 1'b0;
            active  <= 1'b0;
        end else begin
            case (st)
                ST_SHIFT_IN: begin
                    if (scl_rise && bit_cnt != LAST_BIT) begin
                        sh_in   <= {sh_in[BYTE_W-2:0], sda_s};
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (scl_fall && bit_cnt == LAST_BIT) begin
                        if (!is_addr || hit_own || hit_gc) begin
                            sda_oe <= 1'b1;
                            st     <= ST_ACK_OUT;
                            if (is_addr) begin
                                active  <= 1'b1;
                                rd_mode <= is_read && !hit_gc;
                            end
                        end else begin
                            st <= ST_IDLE;
                        end
                    end
                end
                ST_ACK_OUT: begin
                    if (scl_fall) begin
                        sda_oe  <= 1'b0;
                        scl_oe  <= 1'b1;
                        st      <= ST_HOLD;
                        is_addr <= 1'b0;
                        if (!is_addr) rx_byte <= sh_in;
                    end
                end
                ST_HOLD: begin
                    if (evt_clr) begin
                        scl_oe  <= 1'b0;
                        bit_cnt <= '0;
                        if (rd_mode) begin
                            sh_out <= tx_byte;
                            sda_oe <= !tx_byte[BYTE_W-1];
                            st     <= ST_SHIFT_OUT;
                        end else begin
                            st <= ST_SHIFT_IN;
                        end
                    end
                end
                ST_SHIFT_OUT: begin
                    if (scl_rise) begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (scl_fall && bit_cnt != '0) begin
                        if (bit_cnt == LAST_BIT) begin
                            sda_oe <= 1'b0;
                            st     <= ST_ACK_IN;
                        end else begin
                            sh_out <= sh_out << 1;
                            sda_oe <= !sh_out[BYTE_W-2];
                        end
                    end
                end
                ST_ACK_IN: begin
                    if (scl_rise) begin
                        ack_rx <= !sda_s;
                    end else if (scl_fall) begin
                        if (ack_rx) begin
                            scl_oe <= 1'b1;
                            st     <= ST_HOLD;
                        end else begin
                            st <= ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/i2c_tgt_stretch.sv
// Module i2c_tgt_stretch (top)
// I2C target with own-address and broadcast matching.
// Holds SCL low after each acknowledged byte until the local side clears the event.
// Assumes open-drain lines, with levels read back on scl_i/sda_i.
module i2c_tgt_stretch
    import i2c_tgt_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter bit GCALL_EN    = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              evt_clr,
    output logic              evt,
    output logic [2:0]        evt_code,
    output logic [BYTE_W-1:0] rx_byte
);
    logic              sda_s;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic              hit_own;
    logic              hit_gc;
    logic              is_read;
    logic [BYTE_W-1:0] in_byte;

    i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_tgt_match #(.AW(ADDR_W), .GC_EN(GCALL_EN)) u_match (
        .addr_byte (in_byte),
        .own_addr  (own_addr),
        .hit_own   (hit_own),
        .hit_gc    (hit_gc),
        .is_read   (is_read)
    );

    i2c_tgt_engine u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .hit_own   (hit_own),
        .hit_gc    (hit_gc),
        .is_read   (is_read),
        .tx_byte   (tx_byte),
        .evt_clr   (evt_clr),
        .in_byte   (in_byte),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe),
        .evt       (evt),
        .evt_code  (evt_code),
        .rx_byte   (rx_byte)
    );
endmodule

// File: rtl/i2c_tgt_chk.sv
// Module i2c_tgt_chk
// Property checker for i2c_tgt_stretch, attached with bind.
// Checks the stretch handshake and the SDA drive timing at the top-level ports.
module i2c_tgt_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       scl_oe,
    input logic       sda_oe,
    input logic       evt,
    input logic [2:0] evt_code,
    input logic       evt_clr
);
    // R4
    stretch_needs_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scl_oe |-> evt);

    // R4
    stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_oe && !evt_clr) |=> scl_oe);

    // R4
    stretch_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_oe && evt_clr) |=> !scl_oe);

    // R4
    code_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_oe && $past(scl_oe)) |-> $stable(evt_code));

    // R2
    code_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt |-> (evt_code != 3'd0));

    // R6
    sda_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !$past(scl_i));
endmodule

bind i2c_tgt_stretch i2c_tgt_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .scl_oe   (scl_oe),
    .sda_oe   (sda_oe),
    .evt      (evt),
    .evt_code (evt_code),
    .evt_clr  (evt_clr)
);

// File: tb/tb_i2c_tgt_stretch.sv
// Bench for i2c_tgt_stretch: a behavioural controller model that waits for SCL,
// plus a local-side model that checks events against expected codes.
module tb_i2c_tgt_stretch;
    localparam int HALF = 20;
    localparam int QTR  = 10;
    localparam logic [6:0] OWN = 7'h2A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl_lo = 1'b0;
    logic m_sda_lo = 1'b0;
    logic scl_bus, sda_bus;
    logic scl_oe, sda_oe, evt, evt_clr;
    logic [2:0] evt_code;
    logic [7:0] tx_byte, rx_byte;
    int errs = 0;
    int checks = 0;
    int sda_glitch = 0;
    bit done = 1'b0;

    always #2 clk = !clk;

    assign scl_bus = !(m_scl_lo || scl_oe);
    assign sda_bus = !(m_sda_lo || sda_oe);

    i2c_tgt_stretch dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(OWN), .tx_byte(tx_byte),
        .evt_clr(evt_clr), .evt(evt), .evt_code(evt_code), .rx_byte(rx_byte)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rel_scl();
        m_scl_lo = 1'b0;
        @(negedge clk);
        while (!scl_bus) @(negedge clk);
    endtask

    task automatic send_bit(input bit b);
        m_sda_lo = !b;
        wait_clk(QTR);
        rel_scl();
        wait_clk(HALF);
        m_scl_lo = 1'b1;
        wait_clk(QTR);
    endtask

    task automatic recv_bit(output bit b);
        bit late;
        m_sda_lo = 1'b0;
        wait_clk(QTR);
        rel_scl();
        wait_clk(HALF / 2);
        b = sda_bus;
        wait_clk(HALF / 2);
        late = sda_bus;
        if (late != b) sda_glitch++;
        m_scl_lo = 1'b1;
        wait_clk(QTR);
    endtask

    task automatic do_start();
        m_sda_lo = 1'b0;
        wait_clk(QTR);
        rel_scl();
        wait_clk(HALF);
        m_sda_lo = 1'b1;
        wait_clk(HALF);
        m_scl_lo = 1'b1;
        wait_clk(QTR);
    endtask

    task automatic do_stop();
        m_sda_lo = 1'b1;
        wait_clk(QTR);
        rel_scl();
        wait_clk(HALF);
        m_sda_lo = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic send_byte(input logic [7:0] d, output bit acked);
        bit b;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(b);
        acked = !b;
    endtask

    task automatic recv_byte(output logic [7:0] d, input bit give_ack);
        bit b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            d[i] = b;
        end
        send_bit(!give_ack);
    endtask

    task automatic expect_evt(input string req, input int code, input int stretch);
        chk(req, "evt", int'(evt), 1);
        chk(req, "evt_code", int'(evt_code), code);
        chk(req, "scl_oe", int'(scl_oe), stretch);
    endtask

    task automatic clear_evt(input string req);
        @(negedge clk) evt_clr = 1'b1;
        @(negedge clk) evt_clr = 1'b0;
        chk(req, "evt after clear", int'(evt), 0);
        chk(req, "scl_oe after clear", int'(scl_oe), 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin : main
        bit ack;
        logic [7:0] d;
        int highs;
        evt_clr = 1'b0;
        tx_byte = 8'h00;
        wait_clk(6);
        // R1 reset state
        chk("R1", "scl_oe", int'(scl_oe), 0);
        chk("R1", "sda_oe", int'(sda_oe), 0);
        chk("R1", "evt", int'(evt), 0);
        chk("R1", "evt_code", int'(evt_code), 0);
        rst_n = 1'b1;
        wait_clk(4);
        chk("R1", "evt after reset", int'(evt), 0);

        // R3 foreign address: no ACK, no event, nothing at STOP
        do_start();
        send_byte({7'h33, 1'b0}, ack);
        chk("R3", "foreign ack", int'(ack), 0);
        chk("R3", "foreign evt", int'(evt), 0);
        do_stop();
        chk("R3", "foreign stop evt", int'(evt), 0);

        // R2 own write address, then R5 data bytes
        do_start();
        send_byte({OWN, 1'b0}, ack);
        chk("R2", "own write ack", int'(ack), 1);
        expect_evt("R2", 1, 1);
        chk("R4", "SCL held low", int'(scl_bus), 0);
        clear_evt("R4");
        send_byte(8'hA5, ack);
        chk("R5", "data ack", int'(ack), 1);
        expect_evt("R5", 4, 1);
        chk("R5", "rx_byte", int'(rx_byte), 8'hA5);
        clear_evt("R5");
        send_byte(8'h3C, ack);
        expect_evt("R5", 4, 1);
        chk("R5", "rx_byte second", int'(rx_byte), 8'h3C);

        // R4 stretch held while the controller has released SCL
        m_sda_lo = 1'b1;
        m_scl_lo = 1'b0;
        highs = 0;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (scl_bus) highs++;
        end
        chk("R4", "SCL highs during long stretch", highs, 0);
        chk("R4", "evt still pending", int'(evt), 1);
        clear_evt("R4");
        while (!scl_bus) @(negedge clk);
        wait_clk(HALF);
        m_sda_lo = 1'b0;
        wait_clk(HALF);
        // R8 STOP after being addressed
        expect_evt("R8", 7, 0);
        clear_evt("R8");

        // R3 general call, R8 repeated START to own read, R6/R7 transmit
        do_start();
        send_byte(8'h00, ack);
        chk("R3", "general call ack", int'(ack), 1);
        expect_evt("R3", 3, 1);
        clear_evt("R3");
        send_byte(8'h81, ack);
        expect_evt("R5", 4, 1);
        chk("R5", "rx after broadcast", int'(rx_byte), 8'h81);
        clear_evt("R5");
        do_start();
        expect_evt("R8", 7, 0);
        clear_evt("R8");
        send_byte({OWN, 1'b1}, ack);
        chk("R2", "own read ack", int'(ack), 1);
        expect_evt("R2", 2, 1);
        tx_byte = 8'hC3;
        clear_evt("R6");
        tx_byte = 8'hFF;
        recv_byte(d, 1'b1);
        chk("R6", "first tx byte", int'(d), 8'hC3);
        expect_evt("R7", 5, 1);
        tx_byte = 8'h5A;
        clear_evt("R7");
        recv_byte(d, 1'b0);
        chk("R6", "second tx byte", int'(d), 8'h5A);
        expect_evt("R7", 6, 0);
        chk("R7", "sda_oe after NACK", int'(sda_oe), 0);
        clear_evt("R7");
        chk("R6", "SDA changed while SCL high", sda_glitch, 0);
        do_stop();
        expect_evt("R8", 7, 0);
        clear_evt("R8");

        // R3 broadcast address with read bit is not acknowledged
        do_start();
        send_byte(8'h01, ack);
        chk("R3", "broadcast read ack", int'(ack), 0);
        chk("R3", "broadcast read evt", int'(evt), 0);
        do_stop();
        chk("R3", "stop after unmatched", int'(evt), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule